// File: doc/BRIEF.md
# Configuration Access Sequencer with Read-Modify-Write Workaround

This block sits between a configuration-request source and a flat, memory-mapped configuration window. Each request names a bus, a device/function pair, a byte offset, a size of one, two or four bytes, and a direction. The block checks the request and turns it into one or more 32-bit little-endian accesses on a master port. It then answers with read data and a status code. Only one request is in flight at a time. The request side stays not-ready until the response for the current request has been taken.

A small set of registers on the root-port functions cannot be read directly. For reads that hit those registers, the block first writes zero to a scratch dword of the same function. It then reads the whole containing dword and writes that value straight back. The requested byte or halfword is cut out of the captured dword in logic. Every other legal access is a single bus transfer at the exact offset, with byte enables that match its size and position.

Top module: `cfg_seq`

## Requirements
- R1: The master address is bus·2^20 OR devfn·2^12 OR offset, 28 bits wide. devfn is 8 bits, with the function in devfn[2:0] and the slot in devfn[7:3].
- R2: The offset is 13 bits. On bus 0 with devfn 0, every offset up to 0x1FFF is legal. For any other bus/devfn, only offsets below 0x1000 are legal.
- R3: A request with an illegal offset makes no master access. Its response comes in the cycle after acceptance, with status 2'b01 and read data zero.
- R4: A legal offset that is not naturally aligned for its size, or a size code of 2'b11, gives status 2'b10 with no master access and read data zero. The range check comes first: a request that fails both checks reports 2'b01. Size codes are 2'b00 for one byte, 2'b01 for two bytes and 2'b10 for four bytes. Status 2'b00 means success, and status 2'b11 is never produced.
- R5: A function is a root port when the bus is 0, the function number is below 4, and the slot is 16 or 17. The workaround runs only for legal root-port reads whose offset lies in 0x18..0x33 or 0x158..0x177.
- R6: The workaround makes exactly three master accesses, in this order. First, a write of 32'h0 with byte enables 4'hF to offset 0x10 of the same bus and devfn. Second, a read with enables 4'hF at the dword address offset AND ~3. Third, a write with enables 4'hF to that same address, carrying the value just read.
- R7: On the workaround path, a one-byte read returns dword bits [8·(offset&3)+7 : 8·(offset&3)]. A two-byte read returns the low halfword when offset&3 is 0 and the high halfword otherwise. A four-byte read returns the whole dword. All results are zero-extended.
- R8: Every other legal read is one master read at the exact offset. Its byte enables are 4'b0001 shifted by offset&3 for one byte, 4'b0011 shifted by offset&3 for two bytes, and 4'hF for four bytes. The enabled lanes are shifted down to bit 0 and zero-extended.
- R9: Every legal write, including one that targets a workaround register, is one master write at the exact offset. It uses the enables of R8, with the low bytes of the request data placed in the enabled lanes and the other lanes driven zero. A write returns read data zero.
- R10: req_ready is high only while nothing is in flight. A master request holds its address, direction, enables and data until m_ready. A response holds its status and data until rsp_ready.
- R11: After reset, req_ready is high while m_valid and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Slot in [7:3], function in [2:0] |
| req_off | input | 13 | Byte offset |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2 = dword, 3 = unsupported |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken on this edge when valid |
| rsp_status | output | 2 | 0 ok, 1 offset out of range, 2 misaligned or bad size |
| rsp_rdata | output | 32 | Read data, right-aligned and zero-extended |
| m_valid | output | 1 | Master access pending |
| m_ready | input | 1 | Access completes on this edge; read data valid with it |
| m_write | output | 1 | Master direction |
| m_addr | output | 28 | Byte address in the configuration window |
| m_be | output | 4 | Byte lane enables |
| m_wdata | output | 32 | Lane-placed write data |
| m_rdata | input | 32 | Dword read data |

## Verification
The hardest situation to reach is a read that qualifies for the three-step workaround. It needs bus 0, slot 16 or 17, a function below 4 and an offset inside one of two narrow windows, all at once. Uniform random requests almost never hit it. The stimulus therefore draws bus, slot and offset from weighted pools that favour those windows and their edges, and adds directed reads at 0x17, 0x18, 0x33, 0x34, 0x157, 0x158, 0x177 and 0x178 and at function 4. The memory model stalls m_ready at random and keeps the written data. This makes the write-back visible: its data must equal the value read in the step before it, and a workaround read after an ordinary write to the same register must return what was written.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int BUS_W      = 8;
    localparam int DF_W       = 8;
    localparam int FN_W       = 3;
    localparam int SLOT_W     = DF_W - FN_W;
    localparam int BASE_OFF_W = 12;
    localparam int OFF_W      = BASE_OFF_W + 1;
    localparam int ADDR_W     = BUS_W + DF_W + BASE_OFF_W;
    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int LANE_W     = $clog2(BE_W);

    localparam logic [OFF_W-1:0]  SCRATCH_OFF   = 13'h010;
    localparam logic [OFF_W-1:0]  WIN_A_LO      = 13'h018;
    localparam logic [OFF_W-1:0]  WIN_A_HI      = 13'h034;
    localparam logic [OFF_W-1:0]  WIN_B_LO      = 13'h158;
    localparam logic [OFF_W-1:0]  WIN_B_HI      = 13'h178;
    localparam logic [SLOT_W-1:0] ROOT_SLOT_LO  = 5'd16;
    localparam logic [SLOT_W-1:0] ROOT_SLOT_HI  = 5'd17;
    localparam logic [FN_W-1:0]   ROOT_FN_LIMIT = 3'd4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_RANGE = 2'b01,
        ST_ALIGN = 2'b10
    } status_e;

    typedef enum logic [2:0] {
        P_IDLE,
        P_SCRATCH,
        P_CAPTURE,
        P_RESTORE,
        P_SINGLE,
        P_REPLY
    } phase_e;

    typedef struct packed {
        logic                 write;
        logic [BUS_W-1:0]     bus;
        logic [DF_W-1:0]      devfn;
        logic [OFF_W-1:0]     off;
        size_e                size;
        logic [DATA_W-1:0]    wdata;
    } cfg_req_t;

    function automatic logic [ADDR_W-1:0] win_addr(input logic [BUS_W-1:0] b,
                                                   input logic [DF_W-1:0]  d,
                                                   input logic [OFF_W-1:0] o);
        win_addr = {b, {(DF_W + BASE_OFF_W){1'b0}}}
                 | {{BUS_W{1'b0}}, d, {BASE_OFF_W{1'b0}}}
                 | {{(ADDR_W - OFF_W){1'b0}}, o};
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input size_e s);
        case (s)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [BE_W-1:0] lane_enables(input size_e s, input logic [LANE_W-1:0] lo);
        case (s)
            SZ_BYTE: lane_enables = 4'b0001 << lo;
            SZ_HALF: lane_enables = 4'b0011 << lo;
            default: lane_enables = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/cfg_seq_decode.sv
module cfg_seq_decode
    import cfg_seq_pkg::*;
(
    input  logic               write,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DF_W-1:0]    devfn,
    input  logic [OFF_W-1:0]   off,
    input  size_e              size,
    output status_e            status,
    output logic               use_rmw
);
    logic ext_fn, in_range, aligned, root_port, in_window;

    always_comb begin
        ext_fn   = (bus == '0) && (devfn == '0);
        in_range = ext_fn || (off[OFF_W-1:BASE_OFF_W] == '0);

        case (size)
            SZ_BYTE: aligned = 1'b1;
            SZ_HALF: aligned = ~off[0];
            SZ_WORD: aligned = (off[1:0] == 2'b00);
            default: aligned = 1'b0;
        endcase

        root_port = (bus == '0)
                 && (devfn[FN_W-1:0] < ROOT_FN_LIMIT)
                 && ((devfn[DF_W-1:FN_W] == ROOT_SLOT_LO) || (devfn[DF_W-1:FN_W] == ROOT_SLOT_HI));

        in_window = ((off >= WIN_A_LO) && (off < WIN_A_HI))
                 || ((off >= WIN_B_LO) && (off < WIN_B_HI));

        if (!in_range)     status = ST_RANGE;
        else if (!aligned) status = ST_ALIGN;
        else               status = ST_OK;

        use_rmw = (status == ST_OK) && !write && root_port && in_window;
    end
endmodule

// File: rtl/cfg_seq_lanes.sv
module cfg_seq_lanes
    import cfg_seq_pkg::*;
(
    input  size_e               size,
    input  logic [LANE_W-1:0]   lo,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   dword,
    output logic [BE_W-1:0]     be,
    output logic [DATA_W-1:0]   wlanes,
    output logic [DATA_W-1:0]   rfield
);
    logic [LANE_W+2:0] sh;

    always_comb begin
        sh     = {lo, 3'b000};
        be     = lane_enables(size, lo);
        wlanes = (wdata & size_mask(size)) << sh;
        rfield = (dword >> sh) & size_mask(size);
    end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
    import cfg_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [7:0]         req_bus,
    input  logic [7:0]         req_devfn,
    input  logic [12:0]        req_off,
    input  logic [1:0]         req_size,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [1:0]         rsp_status,
    output logic [31:0]        rsp_rdata,
    output logic               m_valid,
    input  logic               m_ready,
    output logic               m_write,
    output logic [27:0]        m_addr,
    output logic [3:0]         m_be,
    output logic [31:0]        m_wdata,
    input  logic [31:0]        m_rdata
);
    phase_e              phase;
    cfg_req_t            cur;
    status_e             cur_status;
    logic [DATA_W-1:0]   held_dw;
    logic [DATA_W-1:0]   rdata_q;

    status_e             dec_status;
    logic                dec_rmw;
    logic [BE_W-1:0]     ln_be;
    logic [DATA_W-1:0]   ln_wlanes;
    logic [DATA_W-1:0]   ln_rfield;
    logic [DATA_W-1:0]   ln_src;
    logic [OFF_W-1:0]    dw_off;

    cfg_seq_decode u_decode (
        .write   (req_write),
        .bus     (req_bus),
        .devfn   (req_devfn),
        .off     (req_off),
        .size    (size_e'(req_size)),
        .status  (dec_status),
        .use_rmw (dec_rmw)
    );

    assign ln_src = (phase == P_RESTORE) ? held_dw : m_rdata;

    cfg_seq_lanes u_lanes (
        .size   (cur.size),
        .lo     (cur.off[LANE_W-1:0]),
        .wdata  (cur.wdata),
        .dword  (ln_src),
        .be     (ln_be),
        .wlanes (ln_wlanes),
        .rfield (ln_rfield)
    );

    assign dw_off     = {cur.off[OFF_W-1:LANE_W], {LANE_W{1'b0}}};
    assign req_ready  = (phase == P_IDLE);
    assign rsp_valid  = (phase == P_REPLY);
    assign rsp_status = cur_status;
    assign rsp_rdata  = rdata_q;

    always_comb begin
        m_valid = 1'b1;
        m_write = 1'b0;
        m_addr  = win_addr(cur.bus, cur.devfn, dw_off);
        m_be    = '1;
        m_wdata = '0;
        case (phase)
            P_SCRATCH: begin
                m_write = 1'b1;
                m_addr  = win_addr(cur.bus, cur.devfn, SCRATCH_OFF);
            end
            P_CAPTURE: begin
                m_write = 1'b0;
            end
            P_RESTORE: begin
                m_write = 1'b1;
                m_wdata = held_dw;
            end
            P_SINGLE: begin
                m_write = cur.write;
                m_addr  = win_addr(cur.bus, cur.devfn, cur.off);
                m_be    = ln_be;
                m_wdata = cur.write ? ln_wlanes : '0;
            end
            default: begin
                m_valid = 1'b0;
                m_addr  = '0;
                m_be    = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= P_IDLE;
            cur        <= '0;
            cur_status <= ST_OK;
            held_dw    <= '0;
            rdata_q    <= '0;
        end else begin
            case (phase)
                P_IDLE: if (req_valid) begin
                    cur.write  <= req_write;
                    cur.bus    <= req_bus;
                    cur.devfn  <= req_devfn;
                    cur.off    <= req_off;
                    cur.size   <= size_e'(req_size);
                    cur.wdata  <= req_wdata;
                    cur_status <= dec_status;
                    rdata_q    <= '0;
                    if (dec_status != ST_OK) phase <= P_REPLY;
                    else if (dec_rmw)        phase <= P_SCRATCH;
                    else                     phase <= P_SINGLE;
                end
                P_SCRATCH: if (m_ready) phase <= P_CAPTURE;
                P_CAPTURE: if (m_ready) begin
                    held_dw <= m_rdata;
                    phase   <= P_RESTORE;
                end
                P_RESTORE: if (m_ready) begin
                    rdata_q <= ln_rfield;
                    phase   <= P_REPLY;
                end
                P_SINGLE: if (m_ready) begin
                    if (!cur.write) rdata_q <= ln_rfield;
                    phase <= P_REPLY;
                end
                P_REPLY: if (rsp_ready) phase <= P_IDLE;
                default: phase <= P_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [1:0]  rsp_status,
    input logic [31:0] rsp_rdata,
    input logic        m_valid,
    input logic        m_ready,
    input logic        m_write,
    input logic [27:0] m_addr,
    input logic [3:0]  m_be,
    input logic [31:0] m_wdata,
    input logic [31:0] m_rdata
);
    assert_idle_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!m_valid && !rsp_valid));

    assert_master_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)
                                   && $stable(m_be) && $stable(m_wdata)));

    assert_reply_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_rdata)));

    assert_error_no_access_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_status != 2'b00) && !$past(rsp_valid)) |-> $past(req_valid && req_ready));

    assert_status_code_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status != 2'b11));

    assert_restore_value_R6: assert property (@(posedge clk) disable iff (rst)
        (m_valid && $past(m_valid && m_ready && !m_write))
            |-> (m_write && (m_be == 4'hF) && (m_addr == $past(m_addr)) && (m_wdata == $past(m_rdata))));

    assert_lanes_present_R8: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (m_be != 4'h0));
endmodule

bind cfg_seq cfg_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_status (rsp_status),
    .rsp_rdata  (rsp_rdata),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_write    (m_write),
    .m_addr     (m_addr),
    .m_be       (m_be),
    .m_wdata    (m_wdata),
    .m_rdata    (m_rdata)
);

// File: tb/cfg_seq_test.sv
`timescale 1ns/1ps
module cfg_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [12:0] req_off = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic        m_write;
    logic [27:0] m_addr;
    logic [3:0]  m_be;
    logic [31:0] m_wdata;
    logic [31:0] m_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_seq uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
        .m_addr(m_addr), .m_be(m_be), .m_wdata(m_wdata), .m_rdata(m_rdata)
    );

    // memory model and access log
    logic [31:0] mem [logic [25:0]];
    logic        lg_w [4];
    logic [27:0] lg_a [4];
    logic [3:0]  lg_be [4];
    logic [31:0] lg_d [4];
    int          lg_n = 0;

    function automatic logic [31:0] memrd(input logic [25:0] a);
        if (mem.exists(a)) return mem[a];
        return {a[15:0] ^ 16'hA5C3, a[25:10]} ^ 32'h1F2E_3D4C;
    endfunction

    always @(negedge clk) begin
        m_ready = 1'b0;
        if (!rst && m_valid && ($urandom % 4 != 0)) begin
            m_ready = 1'b1;
            if (m_write) begin
                logic [31:0] v;
                v = memrd(m_addr[27:2]);
                for (int i = 0; i < 4; i++)
                    if (m_be[i]) v[8*i +: 8] = m_wdata[8*i +: 8];
                mem[m_addr[27:2]] = v;
            end else begin
                m_rdata = memrd(m_addr[27:2]);
            end
            if (lg_n < 4) begin
                lg_w[lg_n]  = m_write;
                lg_a[lg_n]  = m_addr;
                lg_be[lg_n] = m_be;
                lg_d[lg_n]  = m_wdata;
            end
            lg_n++;
        end
    end

    task automatic cmp(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // reference model functions
    function automatic logic [27:0] f_win(input logic [7:0] b, input logic [7:0] d, input logic [12:0] o);
        return (28'(b) << 20) | (28'(d) << 12) | 28'(o);
    endfunction

    function automatic logic [1:0] f_status(input logic [7:0] b, input logic [7:0] d,
                                            input logic [12:0] o, input logic [1:0] sz);
        if (!(b == 0 && d == 0) && o >= 13'h1000) return 2'b01;
        if (sz == 2'b11) return 2'b10;
        if (sz == 2'b01 && o[0]) return 2'b10;
        if (sz == 2'b10 && o[1:0] != 0) return 2'b10;
        return 2'b00;
    endfunction

    function automatic bit f_root(input logic [7:0] b, input logic [7:0] d);
        return (b == 0) && (d[2:0] < 4) && (d[7:3] == 16 || d[7:3] == 17);
    endfunction

    function automatic bit f_win_reg(input logic [12:0] o);
        return (o >= 13'h018 && o < 13'h034) || (o >= 13'h158 && o < 13'h178);
    endfunction

    function automatic logic [31:0] f_extract(input logic [1:0] sz, input logic [1:0] lo, input logic [31:0] dw);
        case (sz)
            2'b00:   return (dw >> (8 * lo)) & 32'hFF;
            2'b01:   return (lo == 0) ? (dw & 32'hFFFF) : ((dw >> 16) & 32'hFFFF);
            default: return dw;
        endcase
    endfunction

    function automatic logic [3:0] f_be(input logic [1:0] sz, input logic [1:0] lo);
        case (sz)
            2'b00:   return 4'(1 << lo);
            2'b01:   return (lo == 0) ? 4'h3 : 4'hC;
            default: return 4'hF;
        endcase
    endfunction

    function automatic logic [31:0] f_lanes(input logic [1:0] sz, input logic [1:0] lo, input logic [31:0] wd);
        case (sz)
            2'b00:   return (wd & 32'hFF) << (8 * lo);
            2'b01:   return (lo == 0) ? (wd & 32'hFFFF) : ((wd & 32'hFFFF) << 16);
            default: return wd;
        endcase
    endfunction

    task automatic run(input bit wr, input logic [7:0] b, input logic [7:0] d,
                       input logic [12:0] o, input logic [1:0] sz, input logic [31:0] wd,
                       input string rq);
        logic [1:0]  est;
        bit          wa;
        logic [27:0] dwa;
        logic [31:0] pre;
        logic [31:0] erd;
        logic [1:0]  s0;
        logic [31:0] d0;
        int          en;
        logic        ew [4];
        logic [27:0] ea [4];
        logic [3:0]  eb [4];
        logic [31:0] ed [4];

        est = f_status(b, d, o, sz);
        wa  = (est == 2'b00) && !wr && f_root(b, d) && f_win_reg(o);
        dwa = f_win(b, d, {o[12:2], 2'b00});
        pre = memrd(dwa[27:2]);
        erd = '0;
        en  = 0;
        if (est == 2'b00 && wa) begin
            en = 3;
            ew[0] = 1'b1; ea[0] = f_win(b, d, 13'h010); eb[0] = 4'hF; ed[0] = 32'h0;
            ew[1] = 1'b0; ea[1] = dwa;                  eb[1] = 4'hF; ed[1] = 32'h0;
            ew[2] = 1'b1; ea[2] = dwa;                  eb[2] = 4'hF; ed[2] = pre;
            erd = f_extract(sz, o[1:0], pre);
        end else if (est == 2'b00) begin
            en = 1;
            ew[0] = wr; ea[0] = f_win(b, d, o); eb[0] = f_be(sz, o[1:0]);
            ed[0] = f_lanes(sz, o[1:0], wd);
            if (!wr) erd = f_extract(sz, o[1:0], pre);
        end

        while (!req_ready) @(negedge clk);
        lg_n = 0;
        req_write = wr; req_bus = b; req_devfn = d; req_off = o; req_size = sz; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cmp("R10", "req_ready while busy", 32'(req_ready), 32'h0);
        while (!rsp_valid) @(negedge clk);
        s0 = rsp_status;
        d0 = rsp_rdata;
        repeat ($urandom % 3) @(negedge clk);
        cmp("R10", "response status held", 32'(rsp_status), 32'(s0));
        cmp("R10", "response data held", rsp_rdata, d0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;

        cmp(rq, "status", 32'(s0), 32'(est));
        cmp(rq, "read data", d0, erd);
        cmp(rq, "access count", 32'(lg_n), 32'(en));
        if (lg_n == en) begin
            for (int k = 0; k < en; k++) begin
                cmp(rq, "access direction", 32'(lg_w[k]), 32'(ew[k]));
                cmp("R1", "access address", 32'(lg_a[k]), 32'(ea[k]));
                cmp(rq, "access enables", 32'(lg_be[k]), 32'(eb[k]));
                if (ew[k]) cmp(rq, "access write data", lg_d[k], ed[k]);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        cmp("R11", "req_ready in reset", 32'(req_ready), 32'h1);
        cmp("R11", "m_valid in reset", 32'(m_valid), 32'h0);
        cmp("R11", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R11", "req_ready after reset", 32'(req_ready), 32'h1);
        cmp("R11", "rsp_valid after reset", 32'(rsp_valid), 32'h0);

        // R2: extended range on bus 0 / devfn 0
        run(0, 8'h00, 8'h00, 13'h1FFC, 2'b10, 32'h0, "R2");
        run(1, 8'h00, 8'h00, 13'h1002, 2'b01, 32'hBEEF_1234, "R2");
        run(0, 8'h00, 8'h00, 13'h1002, 2'b01, 32'h0, "R2");
        // R3: out of range elsewhere
        run(0, 8'h01, 8'h00, 13'h1000, 2'b10, 32'h0, "R3");
        run(1, 8'h00, 8'h08, 13'h1FFF, 2'b00, 32'h55, "R3");
        run(0, 8'h00, 8'h01, 13'h0FFF, 2'b00, 32'h0, "R2");
        // R4: alignment and size code, range first
        run(0, 8'h02, 8'h10, 13'h0003, 2'b01, 32'h0, "R4");
        run(1, 8'h02, 8'h10, 13'h0006, 2'b10, 32'h1, "R4");
        run(0, 8'h02, 8'h10, 13'h0004, 2'b11, 32'h0, "R4");
        run(0, 8'h03, 8'h10, 13'h1003, 2'b10, 32'h0, "R4");
        // R6 / R7: workaround reads
        run(0, 8'h00, {5'd16, 3'd0}, 13'h0018, 2'b10, 32'h0, "R6");
        run(0, 8'h00, {5'd17, 3'd3}, 13'h0033, 2'b00, 32'h0, "R7");
        run(0, 8'h00, {5'd16, 3'd1}, 13'h015A, 2'b01, 32'h0, "R7");
        run(0, 8'h00, {5'd17, 3'd2}, 13'h0158, 2'b01, 32'h0, "R7");
        run(0, 8'h00, {5'd16, 3'd0}, 13'h0177, 2'b00, 32'h0, "R7");
        // R5: boundaries that must not trigger
        run(0, 8'h00, {5'd16, 3'd4}, 13'h0018, 2'b10, 32'h0, "R5");
        run(0, 8'h00, {5'd16, 3'd0}, 13'h0034, 2'b10, 32'h0, "R5");
        run(0, 8'h00, {5'd16, 3'd0}, 13'h0017, 2'b00, 32'h0, "R5");
        run(0, 8'h00, {5'd16, 3'd0}, 13'h0157, 2'b00, 32'h0, "R5");
        run(0, 8'h00, {5'd17, 3'd0}, 13'h0178, 2'b10, 32'h0, "R5");
        run(0, 8'h00, {5'd18, 3'd0}, 13'h0020, 2'b10, 32'h0, "R5");
        run(0, 8'h01, {5'd16, 3'd0}, 13'h0020, 2'b10, 32'h0, "R5");
        // R9: writes to workaround registers stay single, then read back through the workaround
        run(1, 8'h00, {5'd16, 3'd0}, 13'h001A, 2'b01, 32'h0000_C0DE, "R9");
        run(0, 8'h00, {5'd16, 3'd0}, 13'h0018, 2'b10, 32'h0, "R6");
        run(1, 8'h00, {5'd17, 3'd1}, 13'h0160, 2'b10, 32'hDEAD_BEEF, "R9");
        run(0, 8'h00, {5'd17, 3'd1}, 13'h0163, 2'b00, 32'h0, "R7");
        // R8: plain sub-dword reads and writes in every lane
        for (int l = 0; l < 4; l++) begin
            run(1, 8'h05, 8'h21, 13'(13'h0040 + l), 2'b00, 32'(8'hA0 + l), "R9");
            run(0, 8'h05, 8'h21, 13'(13'h0040 + l), 2'b00, 32'h0, "R8");
        end
        run(0, 8'h05, 8'h21, 13'h0042, 2'b01, 32'h0, "R8");
        run(0, 8'h05, 8'h21, 13'h0040, 2'b10, 32'h0, "R8");

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            logic [7:0]  rb, rd;
            logic [12:0] ro;
            logic [1:0]  rs;
            bit          rw;
            case ($urandom % 4)
                0, 1:    rb = 8'h00;
                2:       rb = 8'h01;
                default: rb = 8'($urandom);
            endcase
            case ($urandom % 4)
                0:       rd = 8'h00;
                1:       rd = {5'd16, 3'($urandom)};
                2:       rd = {5'd17, 3'($urandom)};
                default: rd = 8'($urandom);
            endcase
            case ($urandom % 4)
                0:       ro = 13'(13'h010 + $urandom % 13'h030);
                1:       ro = 13'(13'h150 + $urandom % 13'h030);
                2:       ro = 13'($urandom);
                default: ro = 13'($urandom % 13'h1000);
            endcase
            rs = ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
            if ($urandom % 6 != 0) begin
                if (rs == 2'b01) ro[0] = 1'b0;
                if (rs == 2'b10) ro[1:0] = 2'b00;
            end
            rw = 1'($urandom % 2);
            run(rw, rb, rd, ro, rs, $urandom, "R5");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule